// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

This block sits between a received byte stream and packet memory and decides, frame by frame, whether the frame is kept. A frame is recognised only while carrier sense is present. Optionally, carrier sense must also have been present for a fixed settling time. The block forwards every byte of a recognised frame as it arrives and delays the keep/discard verdict to the end marker. The memory side can therefore commit or drop the buffered frame at that point.

The destination address is judged against several rules: an exact match with the station address, a 64-bit hash table for group addresses, an accept-all-groups mode and an accept-everything mode. A frame that the station is sending itself in half duplex is always rejected. Oversize frames are cut off and latch a sticky abort flag. When requested, the trailing four check bytes are held back and never written out.

Top module: `rx_frame_filter`

## Requirements
- R1: While `rst_n` is low, or on every clock edge where `softReset` is high, the block emits no byte and no end marker and clears `abortFlag`. A frame in progress is dropped without an end marker. Bytes that arrive after release without a start marker are ignored.
- R2: `rxEnable` is sampled only when a start marker arrives. With it low, the frame is ignored entirely. If it is cleared during a frame, that frame still completes with its normal verdict, and the next frame is ignored.
- R3: A start marker is honoured only while `carrierSense` is high. With `filterCarrier` set, carrier sense must also have been high on the FILTER_CYCLES (default 12) preceding clock edges. A start marker arriving earlier than that is ignored together with the rest of its frame.
- R4: Destination byte i is the i-th received byte, and `indAddr[8i+7:8i]` holds the address byte it is compared with. A frame whose first destination bit (bit 0 of byte 0) is 0 is kept only if all six bytes match `indAddr`, or if `promisc` is set.
- R5: A frame whose first destination bit is 1 is kept if `allMulti` is set, or if `mcastTable[h]` is 1. Here h is bits 31..26 of a CRC-32 register that starts at all ones, is updated LSB-first with the reflected polynomial 0xEDB88320 over the six destination bytes, and is not inverted.
- R6: With `promisc` set, every frame is kept unless R7 or R8 applies.
- R7: If `txActive` is high and `fullDuplex` is low when the start marker arrives, the frame is discarded even in promiscuous mode.
- R8: A frame with fewer than six bytes is discarded.
- R9: With stripping off, each byte of a recognised frame appears on `outData`/`outValid` one clock after it is accepted. The end marker `outEof` and the verdict `outKeep` come with the last byte.
- R10: `stripCrc`, sampled at the start marker, holds back each frame's last four bytes. Output is delayed by four accepted bytes and the end marker rides on the fifth-last byte. In a frame of four bytes or fewer, `outEof` comes with `outValid` low.
- R11: The byte that would make a frame longer than MAX_LEN (default 1532) is not emitted. One clock after it, `outEof` is high, `outKeep` is low and `outValid` is low. `abortFlag` sets, and input is ignored until the input end marker.
- R12: `abortFlag` stays set until a clock edge where `abortClr` is high. If an abort and `abortClr` fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| softReset | input | 1 | Host-held synchronous reset, active high |
| rxEnable | input | 1 | Receiver enable, sampled at frame start |
| filterCarrier | input | 1 | Require settled carrier sense before a start |
| stripCrc | input | 1 | Withhold the last four bytes of each frame |
| allMulti | input | 1 | Keep all group-addressed frames |
| promisc | input | 1 | Keep all frames |
| fullDuplex | input | 1 | Full-duplex operation |
| txActive | input | 1 | Station is transmitting |
| indAddr | input | 48 | Station address, byte i at bits 8i+7:8i |
| mcastTable | input | 64 | Group-address hash table |
| abortClr | input | 1 | Host write clearing the abort flag |
| carrierSense | input | 1 | Carrier present on the medium |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inSof | input | 1 | First byte of a frame |
| inEof | input | 1 | Last byte of a frame |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte |
| outEof | output | 1 | Frame end at the output |
| outKeep | output | 1 | Verdict, valid with outEof |
| abortFlag | output | 1 | Sticky oversize abort flag |

## Verification
Two functions can fall in the same clock: an oversize abort setting the sticky flag and a host write clearing it. The bench drives `abortClr` on exactly the 1533rd byte of a frame and expects the flag set afterwards. It also checks that a clear on its own drops the flag and that an exact 1532-byte frame raises nothing. A second collision, `rxEnable` falling in the middle of a frame, is judged by the verdict and byte count of that frame and by the silence of the following one.

// File: rtl/rxff_pkg.sv
package rxff_pkg;

  localparam int ADDR_BYTES = 6;

  typedef struct packed {
    logic start;   // first byte of an admitted frame
    logic take;    // byte accepted into the frame
    logic finish;  // frame ends normally on this byte
    logic abort;   // frame cut off for length
  } rxffStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DROP = 2'd2
  } rxffState_t;

  // One byte of reflected CRC-32, LSB first, no inversion.
  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ d[k]) r = {1'b0, r[31:1]} ^ 32'hEDB88320;
      else             r = {1'b0, r[31:1]};
    end
    return r;
  endfunction

endpackage

// File: rtl/rxff_ctrl.sv
module rxff_ctrl
  import rxff_pkg::*;
#(
  parameter int FILTER_CYCLES = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        softReset,
  input  logic        rxEnable,
  input  logic        filterCarrier,
  input  logic        abortClr,
  input  logic        carrierSense,
  input  logic        inValid,
  input  logic        inSof,
  input  logic        inEof,
  input  logic        overLen,
  output rxffStrobe_t stb,
  output logic        abortFlag
);

  localparam int CRS_W = $clog2(FILTER_CYCLES + 1);
  localparam logic [CRS_W-1:0] CRS_FULL = CRS_W'(FILTER_CYCLES);

  rxffState_t       state, stateNext;
  logic [CRS_W-1:0] crsCnt;
  logic             crsOk;
  logic             sofGo;

  // Consecutive cycles of carrier sense, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                crsCnt <= '0;
    else if (softReset)        crsCnt <= '0;
    else if (!carrierSense)    crsCnt <= '0;
    else if (crsCnt != CRS_FULL) crsCnt <= crsCnt + CRS_W'(1);
  end

  assign crsOk = carrierSense && (!filterCarrier || (crsCnt == CRS_FULL));
  assign sofGo = inValid && inSof && rxEnable && crsOk;

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (sofGo) begin
          stb.start = 1'b1;
          stb.take  = 1'b1;
          if (inEof) stb.finish = 1'b1;
          else       stateNext  = ST_RECV;
        end
      end
      ST_RECV: begin
        if (inValid) begin
          if (overLen) begin
            stb.abort = 1'b1;
            stateNext = inEof ? ST_IDLE : ST_DROP;
          end else begin
            stb.take = 1'b1;
            if (inEof) begin
              stb.finish = 1'b1;
              stateNext  = ST_IDLE;
            end
          end
        end
      end
      ST_DROP: begin
        if (inValid && inEof) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
    if (softReset) begin
      stb       = '0;
      stateNext = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  // Sticky abort: set wins over a clear on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         abortFlag <= 1'b0;
    else if (softReset) abortFlag <= 1'b0;
    else if (stb.abort) abortFlag <= 1'b1;
    else if (abortClr)  abortFlag <= 1'b0;
  end

  assert_idle_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !rxEnable) |=> (state == ST_IDLE));

  assert_start_needs_carrier_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.start && filterCarrier) |-> (carrierSense && $past(carrierSense)));

  assert_abort_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.abort && !softReset) |=> abortFlag);

  assert_abort_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (abortFlag && !abortClr && !softReset) |=> abortFlag);

  assert_soft_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    softReset |=> (!abortFlag && state == ST_IDLE));

endmodule

// File: rtl/rxff_datapath.sv
module rxff_datapath
  import rxff_pkg::*;
#(
  parameter int MAX_LEN     = 1532,
  parameter int STRIP_BYTES = 4,
  parameter int HASH_BITS   = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      softReset,
  input  rxffStrobe_t               stb,
  input  logic [7:0]                inData,
  input  logic                      stripCrc,
  input  logic                      promisc,
  input  logic                      allMulti,
  input  logic                      txActive,
  input  logic                      fullDuplex,
  input  logic [8*ADDR_BYTES-1:0]   indAddr,
  input  logic [(1<<HASH_BITS)-1:0] mcastTable,
  output logic                      overLen,
  output logic                      outValid,
  output logic [7:0]                outData,
  output logic                      outEof,
  output logic                      outKeep
);

  localparam int CNT_W  = $clog2(MAX_LEN + 1);
  localparam int FILL_W = $clog2(STRIP_BYTES + 1);
  localparam logic [CNT_W-1:0]  ADDR_CNT = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0]  LEN_CAP  = CNT_W'(MAX_LEN);
  localparam logic [FILL_W-1:0] FILL_CAP = FILL_W'(STRIP_BYTES);

  logic [CNT_W-1:0]        byteCnt, cntBase, cntNext;
  logic [8*ADDR_BYTES-1:0] daReg, daNext;
  logic [31:0]             crcReg, crcBase, crcNext;
  logic [FILL_W-1:0]       fill, fillBase;
  logic [7:0]              pipe [STRIP_BYTES];
  logic                    stripMode, selfBlock;
  logic                    stripNow, selfNow;
  logic [HASH_BITS-1:0]    hashIdx;
  logic                    isGroup, addrOk, keepNow, pipeFull;

  // Per-frame bases: a start restarts counting, address and hash.
  always_comb begin
    cntBase  = stb.start ? '0 : byteCnt;
    crcBase  = stb.start ? '1 : crcReg;
    fillBase = stb.start ? '0 : fill;
    daNext   = stb.start ? '0 : daReg;
    crcNext  = crcBase;
    if (stb.take && (cntBase < ADDR_CNT)) begin
      crcNext = crcStep(crcBase, inData);
      for (int i = 0; i < ADDR_BYTES; i++) begin
        if (cntBase == CNT_W'(i)) daNext[8*i +: 8] = inData;
      end
    end
    cntNext = cntBase + CNT_W'(stb.take);
  end

  assign overLen  = (byteCnt == LEN_CAP);
  assign stripNow = stb.start ? stripCrc : stripMode;
  assign selfNow  = stb.start ? (txActive && !fullDuplex) : selfBlock;
  assign pipeFull = (fillBase == FILL_CAP);

  // Address verdict, formed from the state including the current byte.
  assign isGroup = daNext[0];
  assign hashIdx = crcNext[31 -: HASH_BITS];
  assign addrOk  = promisc ||
                   (isGroup ? (allMulti || mcastTable[hashIdx]) : (daNext == indAddr));
  assign keepNow = !selfNow && (cntNext >= ADDR_CNT) && addrOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byteCnt   <= '0;
      daReg     <= '0;
      crcReg    <= '0;
      fill      <= '0;
      stripMode <= 1'b0;
      selfBlock <= 1'b0;
    end else if (softReset) begin
      byteCnt   <= '0;
      daReg     <= '0;
      crcReg    <= '0;
      fill      <= '0;
      stripMode <= 1'b0;
      selfBlock <= 1'b0;
    end else begin
      if (stb.take) begin
        byteCnt <= cntNext;
        daReg   <= daNext;
        crcReg  <= crcNext;
        fill    <= pipeFull ? fillBase : fillBase + FILL_W'(1);
      end
      if (stb.start) begin
        stripMode <= stripCrc;
        selfBlock <= txActive && !fullDuplex;
      end
    end
  end

  // Hold-back shift register: newest byte at the top, oldest at index 0.
  for (genvar g = 0; g < STRIP_BYTES; g++) begin : g_pipe
    if (g == STRIP_BYTES - 1) begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pipe[g] <= '0;
        else if (stb.take) pipe[g] <= inData;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pipe[g] <= '0;
        else if (stb.take) pipe[g] <= pipe[g+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outData  <= '0;
      outEof   <= 1'b0;
      outKeep  <= 1'b0;
    end else if (softReset) begin
      outValid <= 1'b0;
      outData  <= '0;
      outEof   <= 1'b0;
      outKeep  <= 1'b0;
    end else begin
      outValid <= stb.take && (!stripNow || pipeFull);
      outData  <= stripNow ? pipe[0] : inData;
      outEof   <= stb.finish || stb.abort;
      outKeep  <= stb.finish && keepNow;
    end
  end

  assert_abort_discards_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.abort && !softReset) |=> (outEof && !outKeep && !outValid));

  assert_self_rx_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.finish && !stb.start && selfBlock && !softReset) |=> (outEof && !outKeep));

  assert_strip_holds_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.start && stripCrc && !softReset) |=> !outValid);

  assert_short_discarded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.finish && !stb.start && (byteCnt < ADDR_CNT - CNT_W'(1)) && !softReset) |=> !outKeep);

endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rxff_pkg::*;
#(
  parameter int MAX_LEN       = 1532,
  parameter int FILTER_CYCLES = 12,
  parameter int STRIP_BYTES   = 4,
  parameter int HASH_BITS     = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      softReset,
  input  logic                      rxEnable,
  input  logic                      filterCarrier,
  input  logic                      stripCrc,
  input  logic                      allMulti,
  input  logic                      promisc,
  input  logic                      fullDuplex,
  input  logic                      txActive,
  input  logic [47:0]               indAddr,
  input  logic [(1<<HASH_BITS)-1:0] mcastTable,
  input  logic                      abortClr,
  input  logic                      carrierSense,
  input  logic                      inValid,
  input  logic [7:0]                inData,
  input  logic                      inSof,
  input  logic                      inEof,
  output logic                      outValid,
  output logic [7:0]                outData,
  output logic                      outEof,
  output logic                      outKeep,
  output logic                      abortFlag
);

  rxffStrobe_t stb;
  logic        overLen;

  rxff_ctrl #(
    .FILTER_CYCLES(FILTER_CYCLES)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .softReset    (softReset),
    .rxEnable     (rxEnable),
    .filterCarrier(filterCarrier),
    .abortClr     (abortClr),
    .carrierSense (carrierSense),
    .inValid      (inValid),
    .inSof        (inSof),
    .inEof        (inEof),
    .overLen      (overLen),
    .stb          (stb),
    .abortFlag    (abortFlag)
  );

  rxff_datapath #(
    .MAX_LEN    (MAX_LEN),
    .STRIP_BYTES(STRIP_BYTES),
    .HASH_BITS  (HASH_BITS)
  ) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .softReset (softReset),
    .stb       (stb),
    .inData    (inData),
    .stripCrc  (stripCrc),
    .promisc   (promisc),
    .allMulti  (allMulti),
    .txActive  (txActive),
    .fullDuplex(fullDuplex),
    .indAddr   (indAddr),
    .mcastTable(mcastTable),
    .overLen   (overLen),
    .outValid  (outValid),
    .outData   (outData),
    .outEof    (outEof),
    .outKeep   (outKeep)
  );

endmodule

// File: tb/rx_frame_filter_tb.sv
module rx_frame_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        softReset = 1'b0;
  logic        rxEnable = 1'b0;
  logic        filterCarrier = 1'b0;
  logic        stripCrc = 1'b0;
  logic        allMulti = 1'b0;
  logic        promisc = 1'b0;
  logic        fullDuplex = 1'b0;
  logic        txActive = 1'b0;
  logic [47:0] indAddr = 48'h55_44_33_22_11_02;
  logic [63:0] mcastTable = '0;
  logic        abortClr = 1'b0;
  logic        carrierSense = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inSof = 1'b0;
  logic        inEof = 1'b0;
  logic        outValid, outEof, outKeep, abortFlag;
  logic [7:0]  outData;

  always #5 clk = ~clk;

  rx_frame_filter u_dut (
    .clk(clk), .rst_n(rst_n), .softReset(softReset), .rxEnable(rxEnable),
    .filterCarrier(filterCarrier), .stripCrc(stripCrc), .allMulti(allMulti),
    .promisc(promisc), .fullDuplex(fullDuplex), .txActive(txActive),
    .indAddr(indAddr), .mcastTable(mcastTable), .abortClr(abortClr),
    .carrierSense(carrierSense), .inValid(inValid), .inData(inData),
    .inSof(inSof), .inEof(inEof), .outValid(outValid), .outData(outData),
    .outEof(outEof), .outKeep(outKeep), .abortFlag(abortFlag)
  );

  localparam logic [47:0] DA_OWN   = 48'h55_44_33_22_11_02;
  localparam logic [47:0] DA_OTHER = 48'h55_44_33_22_11_06;
  localparam logic [47:0] DA_GRP   = 48'h01_00_00_5E_00_01;
  localparam logic [47:0] DA_BCAST = 48'hFFFF_FFFF_FFFF;

  // [31:30] address kind, [29] table hit, [28:18] length, [17] promisc,
  // [16] allMulti, [15] strip, [14] txActive, [13] fullDuplex, [12] expected keep
  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 1'b0, 11'd64, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 12'd0}, // R4 own address
    {2'd1, 1'b0, 11'd64, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'd0}, // R4 foreign
    {2'd1, 1'b0, 11'd64, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 12'd0}, // R6 promiscuous
    {2'd2, 1'b1, 11'd64, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 12'd0}, // R5 hash hit
    {2'd2, 1'b0, 11'd64, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'd0}, // R5 hash miss
    {2'd2, 1'b0, 11'd64, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'd0}, // R5 all groups
    {2'd3, 1'b0, 11'd64, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'd0}, // R5 broadcast
    {2'd0, 1'b0, 11'd64, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 12'd0}, // R10 strip
    {2'd1, 1'b0, 11'd64, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'd0}, // R7 half duplex
    {2'd1, 1'b0, 11'd64, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 12'd0}, // R7 full duplex
    {2'd0, 1'b0, 11'd5,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'd0}, // R8 short
    {2'd0, 1'b0, 11'd6,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 12'd0}  // R8 minimum, R10
  };

  int checks = 0;
  int errors = 0;
  int gotCnt = 0;
  int eofCnt = 0;
  logic lastKeep = 1'b0;
  logic eofNow = 1'b0;
  logic [7:0] gotBytes [2048];

  always @(negedge clk) begin
    if (outValid) begin
      if (gotCnt < 2048) gotBytes[gotCnt] = outData;
      gotCnt = gotCnt + 1;
    end
    if (outEof) begin
      eofCnt = eofCnt + 1;
      lastKeep = outKeep;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byteAt(input logic [47:0] da, input int i);
    if (i < 6) return da[8*i +: 8];
    return 8'((i * 7 + 3) & 255);
  endfunction

  function automatic logic [5:0] refHash(input logic [47:0] da);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      for (int k = 0; k < 8; k++) begin
        fb = c[0] ^ da[8*b + k];
        c = {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
      end
    end
    return c[31:26];
  endfunction

  task automatic clearMon();
    gotCnt = 0;
    eofCnt = 0;
    lastKeep = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [47:0] da, input int len, input bit sof,
                           input bit eof, input int clrIdx);
    for (int i = 0; i < len; i++) begin
      inValid  = 1'b1;
      inSof    = sof && (i == 0);
      inEof    = eof && (i == len - 1);
      inData   = byteAt(da, i);
      abortClr = (i == clrIdx);
      @(negedge clk);
    end
    inValid  = 1'b0;
    inSof    = 1'b0;
    inEof    = 1'b0;
    abortClr = 1'b0;
    eofNow   = outEof;
  endtask

  task automatic checkBytes(input logic [47:0] da, input int expCnt, input string tag);
    int bad;
    bad = 0;
    check(gotCnt == expCnt, {tag, " byte count"}, gotCnt, expCnt);
    for (int k = 0; k < expCnt && k < gotCnt; k++) begin
      if (gotBytes[k] !== byteAt(da, k)) bad++;
    end
    check(bad == 0, {tag, " byte content mismatches"}, bad, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [47:0] da;
    int len, expCnt;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1: reset state
    check(outValid == 1'b0 && outEof == 1'b0, "R1 outputs quiet after reset", int'(outValid | outEof), 0);
    check(abortFlag == 1'b0, "R1 abort clear after reset", int'(abortFlag), 0);

    rxEnable = 1'b1;
    carrierSense = 1'b1;
    idle(2);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] w;
      w = VEC[v];
      unique case (w[31:30])
        2'd0: da = DA_OWN;
        2'd1: da = DA_OTHER;
        2'd2: da = DA_GRP;
        default: da = DA_BCAST;
      endcase
      len        = int'(w[28:18]);
      promisc    = w[17];
      allMulti   = w[16];
      stripCrc   = w[15];
      txActive   = w[14];
      fullDuplex = w[13];
      mcastTable = w[29] ? (64'd1 << refHash(DA_GRP)) : 64'd0;
      expCnt     = w[15] ? ((len > 4) ? len - 4 : 0) : len;
      clearMon();
      sendFrame(da, len, 1'b1, 1'b1, -1);
      // R9: end marker one clock after the last input byte
      check(eofNow == 1'b1, $sformatf("R9 end marker timing row %0d", v), int'(eofNow), 1);
      idle(3);
      check(eofCnt == 1 && lastKeep == w[12],
            $sformatf("R4/R5/R6/R7/R8 verdict row %0d", v), int'(lastKeep), int'(w[12]));
      checkBytes(da, expCnt, $sformatf("R9/R10 row %0d", v));
    end
    promisc = 1'b0; allMulti = 1'b0; stripCrc = 1'b0; txActive = 1'b0; fullDuplex = 1'b0;
    mcastTable = '0;

    // R2: disabled receiver ignores the frame
    rxEnable = 1'b0;
    clearMon();
    sendFrame(DA_OWN, 20, 1'b1, 1'b1, -1);
    idle(3);
    check(eofCnt == 0 && gotCnt == 0, "R2 disabled frame ignored", gotCnt + eofCnt, 0);
    // R2: clearing mid-frame completes the frame
    rxEnable = 1'b1;
    clearMon();
    fork
      sendFrame(DA_OWN, 30, 1'b1, 1'b1, -1);
      begin idle(5); rxEnable = 1'b0; end
    join
    idle(3);
    check(eofCnt == 1 && lastKeep == 1'b1, "R2 frame completes after disable", int'(lastKeep), 1);
    check(gotCnt == 30, "R2 full length after disable", gotCnt, 30);
    clearMon();
    sendFrame(DA_OWN, 20, 1'b1, 1'b1, -1);
    idle(3);
    check(eofCnt == 0, "R2 next frame ignored", eofCnt, 0);
    rxEnable = 1'b1;

    // R3: carrier sense gating and filter
    carrierSense = 1'b0;
    idle(2);
    clearMon();
    sendFrame(DA_OWN, 20, 1'b1, 1'b1, -1);
    idle(3);
    check(eofCnt == 0, "R3 no carrier ignored", eofCnt, 0);
    filterCarrier = 1'b1;
    carrierSense = 1'b1;
    idle(11);
    clearMon();
    sendFrame(DA_OWN, 20, 1'b1, 1'b1, -1);
    idle(3);
    check(eofCnt == 0 && gotCnt == 0, "R3 early start filtered", eofCnt + gotCnt, 0);
    carrierSense = 1'b0;
    idle(2);
    carrierSense = 1'b1;
    idle(12);
    clearMon();
    sendFrame(DA_OWN, 20, 1'b1, 1'b1, -1);
    idle(3);
    check(eofCnt == 1 && lastKeep == 1'b1, "R3 settled start accepted", eofCnt, 1);
    filterCarrier = 1'b0;

    // R10: strip mode sampled at start; tiny frame ends without a byte
    clearMon();
    fork
      sendFrame(DA_OWN, 40, 1'b1, 1'b1, -1);
      begin idle(3); stripCrc = 1'b1; end
    join
    idle(3);
    check(gotCnt == 40, "R10 strip latched at start", gotCnt, 40);
    clearMon();
    sendFrame(DA_OWN, 3, 1'b1, 1'b1, -1);
    check(eofNow == 1'b1 && outValid == 1'b0, "R10 short strip end without byte",
          int'(outValid), 0);
    idle(3);
    check(gotCnt == 0 && eofCnt == 1 && lastKeep == 1'b0, "R10/R8 short strip verdict",
          gotCnt, 0);
    stripCrc = 1'b0;

    // R11: oversize frame
    clearMon();
    sendFrame(DA_OWN, 1540, 1'b1, 1'b1, -1);
    idle(3);
    check(eofCnt == 1 && lastKeep == 1'b0, "R11 oversize discarded", int'(lastKeep), 0);
    check(gotCnt == 1532, "R11 bytes before abort", gotCnt, 1532);
    check(abortFlag == 1'b1, "R11 abort flag set", int'(abortFlag), 1);
    idle(5);
    check(abortFlag == 1'b1, "R12 abort flag sticky", int'(abortFlag), 1);
    abortClr = 1'b1;
    idle(1);
    abortClr = 1'b0;
    check(abortFlag == 1'b0, "R12 host clear", int'(abortFlag), 0);
    clearMon();
    sendFrame(DA_OWN, 1532, 1'b1, 1'b1, -1);
    idle(3);
    check(eofCnt == 1 && lastKeep == 1'b1 && gotCnt == 1532, "R11 maximum length kept",
          gotCnt, 1532);
    check(abortFlag == 1'b0, "R11 no abort at maximum", int'(abortFlag), 0);
    // R12: clear on the aborting byte loses to the abort
    clearMon();
    sendFrame(DA_OWN, 1533, 1'b1, 1'b1, 1532);
    idle(3);
    check(abortFlag == 1'b1, "R12 abort wins over clear", int'(abortFlag), 1);
    check(eofCnt == 1 && lastKeep == 1'b0, "R11 abort on final byte", int'(lastKeep), 0);

    // R1: soft reset drops the frame and the flag
    clearMon();
    sendFrame(DA_OWN, 10, 1'b1, 1'b0, -1);
    softReset = 1'b1;
    idle(2);
    check(abortFlag == 1'b0 && outValid == 1'b0, "R1 soft reset clears", int'(abortFlag), 0);
    softReset = 1'b0;
    sendFrame(DA_OWN, 10, 1'b0, 1'b1, -1);
    idle(3);
    check(eofCnt == 0, "R1 dropped frame never ends", eofCnt, 0);
    clearMon();
    sendFrame(DA_OWN, 16, 1'b1, 1'b1, -1);
    idle(3);
    check(eofCnt == 1 && lastKeep == 1'b1, "R1 receives after soft reset", int'(lastKeep), 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule